// File: doc/BRIEF.md
# Code-Flow Integrity Watchdog

This block watches whether software runs its protected code along the intended path. Software opens a protected section by writing a start value. That value seeds a secure counter and arms a countdown instruction timer. At each checkpoint software adds or subtracts a known step. At the end it writes the value the counter must hold by then. If the path or the timing deviates, a fault flag is raised. Each fault kind can then be routed to an interrupt request, to a reset request, or to nothing.

Access is through a word-indexed register bus. Writes complete in one cycle and reads return combinationally. Register offsets (word index): 0 control, 1 flags, 2 reload, 3 start, 4 stop, 5 restart, 6 add value, 7 add one, 8 add sixteen, 9 add 256, 10 subtract value, 11 subtract one, 12 subtract sixteen, 13 subtract 256, 14 scratch word, 15 timer readback. Offsets of 16 and above are unmapped.

The block is either idle or armed. The control word can only be changed while the block is idle. Two inputs let the timer freeze while an interrupt is being serviced or while a debugger holds the core.

Top module: `flowguard_top`

## Requirements
- R1: After reset the control word (offset 0) reads 0x800, the flags (offset 1) read 0x40 (power-on bit 6 only), the timer (offset 15) reads 0, and `irq_req` and `rst_req` are low.
- R2: A write to offset 3 while idle loads the secure counter with the written data, loads the timer from the reload word (offset 2), and arms the block.
- R3: While armed, offsets 6 and 10 add or subtract the written data. Offsets 7/8/9 add 1/16/256 and offsets 11/12/13 subtract 1/16/256 whatever the data. The counter wraps modulo 2^CNT_W, and a result outside that range sets flag bit 3.
- R4: A write to offset 4 while armed compares the written data with the counter, sets flag bit 1 on a mismatch, stops the timer and returns the block to idle.
- R5: A write to offset 5 while armed does the same compare, then reloads the counter with the written data and the timer from the reload word, and the block stays armed.
- R6: While armed and not frozen, the timer drops by one per clock. The clock edge after it has read zero sets flag bit 0 and returns the block to idle.
- R7: The timer holds its value while control bit 10 and `irq_active` are both set, or while control bit 12 and `debug_active` are both set. Either input alone, with its control bit clear, does not hold it.
- R8: A start write while armed, or a stop, restart, add or subtract write while idle, sets flag bit 2 and leaves the counter and the timer unchanged.
- R9: The control word reads 0 while armed. A control write while armed sets flag bit 4 and leaves the stored control word unchanged.
- R10: A read or write at an unmapped offset sets flag bit 5.
- R11: Control bits [1:0], [3:2], [5:4], [7:6] and [9:8] hold the actions for flag bits 0, 1, 2, 4 and 5. Value 1 drives `irq_req` and value 2 drives `rst_req` while that flag is set. Values 0 and 3 do nothing. Writing 1s to offset 1 clears the matching flags.
- R12: A control write whose bit 11 is 0 is ignored. After bit 13 (lock) has been written as 1, control writes are ignored until reset.
- R13: Offset 14 stores a 32-bit word that can be written and read back in either state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_addr | input | ADDR_W | Word offset |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data (combinational) |
| irq_active | input | 1 | Core is servicing an interrupt |
| debug_active | input | 1 | Core is halted by a debugger |
| irq_req | output | 1 | Interrupt request to the system |
| rst_req | output | 1 | Reset request to the system |

## Verification
The bench builds the block with an 8-bit secure counter and a 6-bit timer. This makes counter wrap-around reachable with single add-256, add-16 and subtract-256 steps. Start values are swept across the counter range for every one of the eight step offsets, and the expected results and wrap flags are worked out in wide integer arithmetic. The short timer makes it practical to sweep reload values from 0 upward, checking that the timeout flag appears on exactly the expected edge and on no earlier one.

// File: rtl/flowguard_pkg.sv
package flowguard_pkg;

  localparam int NUM_FLAGS = 7;

  localparam logic [3:0] OFF_CTRL    = 4'd0;
  localparam logic [3:0] OFF_FLAGS   = 4'd1;
  localparam logic [3:0] OFF_RELOAD  = 4'd2;
  localparam logic [3:0] OFF_START   = 4'd3;
  localparam logic [3:0] OFF_STOP    = 4'd4;
  localparam logic [3:0] OFF_RESTART = 4'd5;
  localparam logic [3:0] OFF_ADDV    = 4'd6;
  localparam logic [3:0] OFF_SUBV    = 4'd10;
  localparam logic [3:0] OFF_SUB256  = 4'd13;
  localparam logic [3:0] OFF_SCRATCH = 4'd14;
  localparam logic [3:0] OFF_TIMER   = 4'd15;

  localparam int FLG_TMO   = 0;
  localparam int FLG_MIS   = 1;
  localparam int FLG_SEQ   = 2;
  localparam int FLG_WRAP  = 3;
  localparam int FLG_STATE = 4;
  localparam int FLG_ADDR  = 5;
  localparam int FLG_POR   = 6;

  typedef enum logic [1:0] {
    ACT_NONE = 2'd0,
    ACT_IRQ  = 2'd1,
    ACT_RST  = 2'd2,
    ACT_RSVD = 2'd3
  } act_e;

  typedef struct packed {
    logic lock;
    logic dbg_halt;
    logic rsv_one;
    logic irq_pause;
    act_e a_addr;
    act_e a_state;
    act_e a_seq;
    act_e a_mis;
    act_e a_tmo;
  } ctrl_t;

  localparam ctrl_t CTRL_RESET = 14'h0800;

  // Step size selected by a step offset (6..13): the data word for the
  // free-value offsets, a fixed power of sixteen for the others.
  function automatic logic [31:0] step_amount(input logic [3:0] off,
                                              input logic [31:0] data);
    logic [1:0] sel;
    sel = off[1:0] - 2'd2;
    case (sel)
      2'd0:    step_amount = data;
      2'd1:    step_amount = 32'd1;
      2'd2:    step_amount = 32'd16;
      default: step_amount = 32'd256;
    endcase
  endfunction

  // Exact add or subtract in 33 bits; any bit above the counter width
  // marks a result outside the counter range.
  function automatic logic [32:0] counter_step(input logic [31:0] cur,
                                               input logic [31:0] amt,
                                               input logic        sub);
    counter_step = sub ? ({1'b0, cur} - {1'b0, amt})
                       : ({1'b0, cur} + {1'b0, amt});
  endfunction

endpackage

// File: rtl/flowguard_counter.sv
module flowguard_counter
  import flowguard_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  input  logic             step_en,
  input  logic             step_sub,
  input  logic [31:0]      step_amt,
  input  logic             cmp_en,
  input  logic [CNT_W-1:0] cmp_val,
  output logic             mismatch,
  output logic             wrap
);

  logic [CNT_W-1:0] cnt_q;
  logic [32:0]      step_res;

  always_comb begin
    step_res = counter_step(32'(cnt_q), step_amt, step_sub);
    wrap     = step_en && (step_res[32:CNT_W] != '0);
    mismatch = cmp_en && (cnt_q != cmp_val);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       cnt_q <= '0;
    else if (load)    cnt_q <= load_val;
    else if (step_en) cnt_q <= step_res[CNT_W-1:0];
  end

  // R8: with no load and no step, the counter cannot move
  a_r8_cnt_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && !step_en) |=> $stable(cnt_q));

endmodule

// File: rtl/flowguard_timer.sv
module flowguard_timer #(
  parameter int TMR_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [TMR_W-1:0] load_val,
  input  logic             dec_en,
  output logic [TMR_W-1:0] tmr,
  output logic             expire
);

  logic [TMR_W-1:0] tmr_q;

  assign tmr    = tmr_q;
  assign expire = dec_en && (tmr_q == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                       tmr_q <= '0;
    else if (load)                    tmr_q <= load_val;
    else if (dec_en && tmr_q != '0)   tmr_q <= tmr_q - 1'b1;
  end

  // R7: a frozen or disarmed timer keeps its value
  a_r7_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && !dec_en) |=> $stable(tmr_q));

  // R6: a running timer never rises without a reload
  a_r6_no_rise: assert property (@(posedge clk) disable iff (!rst_n)
    (!load) |=> (tmr_q <= $past(tmr_q)));

endmodule

// File: rtl/flowguard_faults.sv
module flowguard_faults
  import flowguard_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_FLAGS-1:0] evt,
  input  logic                 clr_we,
  input  logic [NUM_FLAGS-1:0] clr_mask,
  input  ctrl_t                ctrl,
  output logic [NUM_FLAGS-1:0] flags,
  output logic                 irq_req,
  output logic                 rst_req
);

  logic [NUM_FLAGS-1:0] flags_q;
  logic [NUM_FLAGS-1:0] irq_vec;
  logic [NUM_FLAGS-1:0] rst_vec;
  act_e                 acts [NUM_FLAGS];

  always_comb begin
    for (int i = 0; i < NUM_FLAGS; i++) acts[i] = ACT_NONE;
    acts[FLG_TMO]   = ctrl.a_tmo;
    acts[FLG_MIS]   = ctrl.a_mis;
    acts[FLG_SEQ]   = ctrl.a_seq;
    acts[FLG_STATE] = ctrl.a_state;
    acts[FLG_ADDR]  = ctrl.a_addr;
  end

  for (genvar i = 0; i < NUM_FLAGS; i++) begin : g_route
    assign irq_vec[i] = flags_q[i] && (acts[i] == ACT_IRQ);
    assign rst_vec[i] = flags_q[i] && (acts[i] == ACT_RST);
  end

  assign flags   = flags_q;
  assign irq_req = |irq_vec;
  assign rst_req = |rst_vec;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flags_q          <= '0;
      flags_q[FLG_POR] <= 1'b1;
    end else begin
      flags_q <= (flags_q & ~(clr_we ? clr_mask : '0)) | evt;
    end
  end

  // R11: a fresh event is always recorded on the next edge
  a_r11_evt_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (|evt) |=> (|flags_q));

  // R11: requests only ever come from a recorded fault
  a_r11_req_src: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_req || rst_req) |-> (flags_q != '0));

endmodule

// File: rtl/flowguard_top.sv
module flowguard_top
  import flowguard_pkg::*;
#(
  parameter int CNT_W  = 32,
  parameter int TMR_W  = 32,
  parameter int ADDR_W = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  input  logic              irq_active,
  input  logic              debug_active,
  output logic              irq_req,
  output logic              rst_req
);

  localparam int CTRL_W = $bits(ctrl_t);

  logic                 running;
  ctrl_t                ctrl_q;
  logic [TMR_W-1:0]     reload_q;
  logic [31:0]          scratch_q;
  logic                 mapped;
  logic [3:0]           off;
  logic                 w_ctrl, w_flags, w_reload, w_start, w_stop;
  logic                 w_restart, w_step, w_scratch;
  logic                 start_ok, stop_ok, restart_ok;
  logic                 seq_err, state_err, bad_addr;
  logic                 hold, dec_en, expire, mismatch, wrap;
  logic [TMR_W-1:0]     tmr;
  logic [NUM_FLAGS-1:0] evt, flags;

  if (ADDR_W > 4) begin : g_hi_addr
    assign mapped = ~|bus_addr[ADDR_W-1:4];
  end else begin : g_no_hi
    assign mapped = 1'b1;
  end

  assign off = bus_addr[3:0];

  always_comb begin
    w_ctrl     = bus_wr && mapped && off == OFF_CTRL;
    w_flags    = bus_wr && mapped && off == OFF_FLAGS;
    w_reload   = bus_wr && mapped && off == OFF_RELOAD;
    w_start    = bus_wr && mapped && off == OFF_START;
    w_stop     = bus_wr && mapped && off == OFF_STOP;
    w_restart  = bus_wr && mapped && off == OFF_RESTART;
    w_step     = bus_wr && mapped && off >= OFF_ADDV && off <= OFF_SUB256;
    w_scratch  = bus_wr && mapped && off == OFF_SCRATCH;
    start_ok   = w_start && !running;
    stop_ok    = w_stop && running;
    restart_ok = w_restart && running;
    seq_err    = (w_start && running) ||
                 ((w_stop || w_restart || w_step) && !running);
    state_err  = w_ctrl && running;
    bad_addr   = (bus_wr || bus_rd) && !mapped;
    hold       = (ctrl_q.irq_pause && irq_active) ||
                 (ctrl_q.dbg_halt && debug_active);
    dec_en     = running && !hold;
  end

  always_comb begin
    evt            = '0;
    evt[FLG_TMO]   = expire;
    evt[FLG_MIS]   = mismatch;
    evt[FLG_SEQ]   = seq_err;
    evt[FLG_WRAP]  = wrap;
    evt[FLG_STATE] = state_err;
    evt[FLG_ADDR]  = bad_addr;
  end

  flowguard_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (start_ok || restart_ok),
    .load_val (bus_wdata[CNT_W-1:0]),
    .step_en  (w_step && running),
    .step_sub (off >= OFF_SUBV),
    .step_amt (step_amount(off, bus_wdata)),
    .cmp_en   (stop_ok || restart_ok),
    .cmp_val  (bus_wdata[CNT_W-1:0]),
    .mismatch (mismatch),
    .wrap     (wrap)
  );

  flowguard_timer #(.TMR_W(TMR_W)) u_tmr (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (start_ok || restart_ok),
    .load_val (reload_q),
    .dec_en   (dec_en),
    .tmr      (tmr),
    .expire   (expire)
  );

  flowguard_faults u_flt (
    .clk      (clk),
    .rst_n    (rst_n),
    .evt      (evt),
    .clr_we   (w_flags),
    .clr_mask (bus_wdata[NUM_FLAGS-1:0]),
    .ctrl     (ctrl_q),
    .flags    (flags),
    .irq_req  (irq_req),
    .rst_req  (rst_req)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      running   <= 1'b0;
      ctrl_q    <= CTRL_RESET;
      reload_q  <= '0;
      scratch_q <= '0;
    end else begin
      if (start_ok || restart_ok)  running <= 1'b1;
      else if (stop_ok || expire)  running <= 1'b0;
      if (w_ctrl && !running && !ctrl_q.lock && bus_wdata[11])
        ctrl_q <= ctrl_t'(bus_wdata[CTRL_W-1:0]);
      if (w_reload)  reload_q  <= bus_wdata[TMR_W-1:0];
      if (w_scratch) scratch_q <= bus_wdata;
    end
  end

  always_comb begin
    bus_rdata = '0;
    if (mapped) begin
      case (off)
        OFF_CTRL:    bus_rdata = running ? 32'd0 : 32'(ctrl_q);
        OFF_FLAGS:   bus_rdata = 32'(flags);
        OFF_RELOAD:  bus_rdata = 32'(reload_q);
        OFF_SCRATCH: bus_rdata = scratch_q;
        OFF_TIMER:   bus_rdata = 32'(tmr);
        default:     bus_rdata = '0;
      endcase
    end
  end

  // R2: an accepted start arms the block
  a_r2_start_arms: assert property (@(posedge clk) disable iff (!rst_n)
    start_ok |=> running);

  // R4: an accepted stop disarms the block
  a_r4_stop_idles: assert property (@(posedge clk) disable iff (!rst_n)
    stop_ok |=> !running);

  // R9: control writes while armed leave the control word alone
  a_r9_ctrl_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    state_err |=> $stable(ctrl_q));

  // R12: a locked control word never changes
  a_r12_lock_holds: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_q.lock |=> $stable(ctrl_q));

endmodule

// File: tb/sim_flowguard_top.sv
`timescale 1ns/1ps
module sim_flowguard_top;

  localparam int CNT_W  = 8;
  localparam int TMR_W  = 6;
  localparam int ADDR_W = 5;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              bus_wr = 1'b0;
  logic              bus_rd = 1'b0;
  logic [ADDR_W-1:0] bus_addr = '0;
  logic [31:0]       bus_wdata = '0;
  logic [31:0]       bus_rdata;
  logic              irq_active = 1'b0;
  logic              debug_active = 1'b0;
  logic              irq_req, rst_req;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  flowguard_top #(.CNT_W(CNT_W), .TMR_W(TMR_W), .ADDR_W(ADDR_W)) u0 (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .irq_active(irq_active), .debug_active(debug_active),
    .irq_req(irq_req), .rst_req(rst_req)
  );

  task automatic chk(input string tag, input longint got, input longint exp);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s: got 0x%0h expected 0x%0h", tag, got, exp);
    end
  endtask

  task automatic wr(input int a, input logic [31:0] d);
    bus_wr = 1'b1; bus_addr = ADDR_W'(a); bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input int a, output logic [31:0] d);
    bus_rd = 1'b1; bus_addr = ADDR_W'(a);
    #1 d = bus_rdata;
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic clr_flags();
    wr(1, 32'h7F);
  endtask

  function automatic longint amount_of(input int k, input logic [31:0] d);
    int m;
    m = k % 4;
    if (m == 0) return longint'(d);
    if (m == 1) return 1;
    if (m == 2) return 16;
    return 256;
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: got hang expected completion");
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    do_reset();

    // R1 reset state
    #1;
    chk("R1 irq_req", irq_req, 0);
    chk("R1 rst_req", rst_req, 0);
    rd(0, d);  chk("R1 ctrl", d, 32'h800);
    rd(1, d);  chk("R1 flags", d, 32'h40);
    rd(15, d); chk("R1 timer", d, 0);

    // R13 scratch word in both states
    wr(14, 32'hA5C3_1E77); rd(14, d); chk("R13 scratch idle", d, 32'hA5C3_1E77);
    wr(2, 50); wr(3, 0);
    wr(14, 32'h0BAD_F00D); rd(14, d); chk("R13 scratch armed", d, 32'h0BAD_F00D);
    wr(4, 0);

    // R2/R3/R4 sweep of start values over every step offset
    for (int v = 0; v < 256; v += 5) begin
      for (int k = 0; k < 8; k++) begin
        logic [31:0] data;
        longint e;
        bit wrapped;
        data = (k == 0 || k == 4) ? 32'(v * 3 + k * 17) : 32'hDEAD_BEEF;
        e = (k < 4) ? longint'(v) + amount_of(k, data)
                    : longint'(v) - amount_of(k, data);
        wrapped = (e < 0) || (e > 255);
        clr_flags();
        wr(3, 32'(v));
        wr(6 + k, data);
        rd(1, d);
        chk("R3 wrap flag", d[3], wrapped);
        wr(4, 32'(e & 255));
        rd(1, d);
        chk("R4 match no miscompare", d[1], 0);
      end
    end

    // R4 mismatch, R2 control reads 0 while armed
    clr_flags();
    wr(3, 33);
    rd(0, d); chk("R2 ctrl reads zero armed", d, 0);
    wr(4, 34);
    rd(1, d); chk("R4 mismatch flag", d[1], 1);
    rd(0, d); chk("R4 idle after stop", d, 32'h800);
    wr(15, 0);

    // R5 restart
    clr_flags();
    wr(2, 40);
    wr(3, 5); wr(7, 0);
    repeat (4) @(negedge clk);
    wr(5, 6);
    rd(1, d);  chk("R5 restart match", d[1], 0);
    rd(15, d); chk("R5 timer reloaded", d, 39);
    rd(0, d);  chk("R5 still armed", d, 0);
    wr(7, 0); wr(4, 7);
    rd(1, d);  chk("R5 counter reloaded", d[1], 0);

    // R6 timer decrement
    wr(2, 40); wr(3, 0);
    rd(15, d); chk("R6 timer after start", d, 40);
    rd(15, d); chk("R6 timer step", d, 39);
    repeat (5) @(negedge clk);
    rd(15, d); chk("R6 timer after gap", d, 33);
    wr(4, 0);

    // R6 timeout edge sweep
    for (int r = 0; r < 13; r++) begin
      clr_flags();
      wr(2, 32'(r));
      wr(3, 0);
      repeat (r) @(negedge clk);
      rd(1, d); chk("R6 no early timeout", d[0], 0);
      rd(1, d); chk("R6 timeout edge", d[0], 1);
      rd(0, d); chk("R6 idle after timeout", d, 32'h800);
    end

    // R7 freeze by interrupt and by debug
    wr(0, 32'h0C00); wr(2, 30);
    irq_active = 1'b1;
    wr(3, 0);
    rd(15, d); chk("R7 irq hold a", d, 30);
    repeat (3) @(negedge clk);
    rd(15, d); chk("R7 irq hold b", d, 30);
    irq_active = 1'b0;
    debug_active = 1'b1;
    rd(15, d); chk("R7 debug without enable", d, 30);
    rd(15, d); chk("R7 runs again", d, 29);
    debug_active = 1'b0;
    wr(4, 0);
    wr(0, 32'h1800);
    debug_active = 1'b1;
    wr(3, 0);
    repeat (3) @(negedge clk);
    rd(15, d); chk("R7 debug hold", d, 30);
    debug_active = 1'b0;
    irq_active = 1'b1;
    rd(15, d); rd(15, d); chk("R7 irq without enable", d, 29);
    irq_active = 1'b0;
    wr(4, 0);
    wr(0, 32'h0800);

    // R8 sequence faults leave counter and timer alone
    clr_flags();
    wr(8, 0);
    rd(1, d); chk("R8 step while idle", d[2], 1);
    clr_flags();
    wr(4, 0);
    rd(1, d); chk("R8 stop while idle", d[2], 1);
    clr_flags();
    wr(2, 40); wr(3, 10);
    wr(3, 99);
    rd(1, d);  chk("R8 start while armed", d[2], 1);
    rd(15, d); chk("R8 timer not reloaded", d, 38);
    wr(4, 10);
    rd(1, d);  chk("R8 counter kept", d[1], 0);

    // R9 control write while armed
    clr_flags();
    wr(3, 0);
    wr(0, 32'h0803);
    rd(1, d); chk("R9 state flag", d[4], 1);
    rd(0, d); chk("R9 reads zero", d, 0);
    wr(4, 0);
    rd(0, d); chk("R9 ctrl unchanged", d, 32'h800);

    // R10 unmapped accesses
    clr_flags();
    wr(20, 32'hFFFF);
    rd(1, d); chk("R10 write unmapped", d[5], 1);
    clr_flags();
    rd(31, d);
    rd(1, d); chk("R10 read unmapped", d[5], 1);

    // R11 action routing
    wr(0, 32'h0836);
    clr_flags();
    #1 chk("R11 quiet irq", irq_req, 0);
    wr(3, 0); wr(4, 1);
    #1;
    chk("R11 miscompare irq", irq_req, 1);
    chk("R11 miscompare no rst", rst_req, 0);
    clr_flags();
    #1 chk("R11 cleared irq", irq_req, 0);
    wr(4, 0);
    #1;
    chk("R11 action3 irq", irq_req, 0);
    chk("R11 action3 rst", rst_req, 0);
    clr_flags();
    wr(2, 2); wr(3, 0);
    repeat (4) @(negedge clk);
    #1 chk("R11 timeout rst", rst_req, 1);
    clr_flags();
    #1 chk("R11 rst cleared", rst_req, 0);

    // R12 reserved bit and lock
    wr(0, 32'h0004);
    rd(0, d); chk("R12 bit11 zero ignored", d, 32'h836);
    wr(0, 32'h2800);
    rd(0, d); chk("R12 lock written", d, 32'h2800);
    wr(0, 32'h0836);
    rd(0, d); chk("R12 locked ignores", d, 32'h2800);
    do_reset();
    rd(0, d); chk("R12 reset unlocks", d, 32'h800);

    done = 1'b1;
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule